// File: doc/BRIEF.md
# Partial-Width General-Purpose Register File

This block holds sixteen 64-bit general-purpose registers and lets each operand reach them at 8, 16, 32 or 64 bits. It has two combinational read ports and one write port that commits on the rising clock edge. Each port takes an already-extracted register specifier: a 3-bit code, an extension bit, a flag saying whether the extending prefix is present, and an operand size. Each port also reports a bad-operand flag when the specifier cannot address any storage.

The prefix flag changes how 8-bit specifiers map to storage. Without the prefix, the upper four byte codes reach the second byte of the first four registers. With the prefix, those codes reach the low byte of registers 4 to 7, and the extension bit opens registers 8 to 15. Reads zero-extend the selected slice. Writes merge it into the stored register by size-specific rules.

Top module: `partreg_file`

## Requirements
- R1: With the prefix flag low, extension 0, and size 16, 32 or 64 bits (size encoding 00=8, 01=16, 10=32, 11=64), code n (0..7) addresses register n.
- R2: With the prefix flag low and size 00, codes 0..3 address bits 7:0 of registers 0..3, and codes 4..7 address bits 15:8 of registers 0..3 (code 4 maps to register 0, code 7 to register 3).
- R3: With the prefix flag high and size 00, the register index is {extension, code} and the slice is always bits 7:0. Codes 4..7 therefore reach the low byte of registers 4..7.
- R4: With the prefix flag high, the register index is {extension, code} at every size, so registers 8..15 can be addressed.
- R5: A specifier with extension 1 and the prefix flag low raises that port's bad flag. A read port then returns zero.
- R6: A write whose specifier raises the bad flag leaves every register unchanged.
- R7: A write of size 00 changes only the addressed byte lane (7:0 or 15:8), and a write of size 01 changes only bits 15:0. All other bits keep their value.
- R8: A write of size 10 stores bits 31:0 of the write data and clears bits 63:32.
- R9: A write of size 11 replaces all 64 bits.
- R10: A read returns the selected slice in the low bits of the read data, with all higher bits zero.
- R11: While the active-low synchronous reset is sampled low at a clock edge, every register is cleared to zero.
- R12: A read of the register being written in the same cycle returns the value held before that write's clock edge.
- R13: With the prefix flag high, no specifier reaches bits 15:8 as a byte operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_code | input | 3 | Read port A register code |
| ra_ext | input | 1 | Read port A extension bit |
| ra_pfx | input | 1 | Read port A prefix-present flag |
| ra_size | input | 2 | Read port A operand size |
| ra_data | output | 64 | Read port A zero-extended data |
| ra_bad | output | 1 | Read port A bad-specifier flag |
| rb_code | input | 3 | Read port B register code |
| rb_ext | input | 1 | Read port B extension bit |
| rb_pfx | input | 1 | Read port B prefix-present flag |
| rb_size | input | 2 | Read port B operand size |
| rb_data | output | 64 | Read port B zero-extended data |
| rb_bad | output | 1 | Read port B bad-specifier flag |
| wr_en | input | 1 | Write enable |
| wr_code | input | 3 | Write register code |
| wr_ext | input | 1 | Write extension bit |
| wr_pfx | input | 1 | Write prefix-present flag |
| wr_size | input | 2 | Write operand size |
| wr_data | input | 64 | Write data, slice taken from the low bits |
| wr_bad | output | 1 | Write bad-specifier flag |

## Verification
The bench loads every register with a pattern in which each byte is distinct. It then sweeps every size, prefix, extension and code on both read ports. A decoder that confused the prefixed and unprefixed byte maps would return a neighbouring register's byte, and one that let the prefix reach a high byte would return bits 15:8 where bits 7:0 belong. Every write specifier, including the bad ones, is then replayed and the whole register read back. This exposes a lost upper half after a 32-bit write, bytes overwritten next to a byte or word lane, and a bad write that still lands. A same-cycle read-during-write check catches a design that forwards the new data.

// File: rtl/prf_pkg.sv
// Shared types for the partial-width register file.
// Assumes sixteen registers addressed by a 4-bit index.
package prf_pkg;
    localparam int IDX_W = 4;

    typedef enum logic [1:0] {
        OPSZ_8  = 2'b00,
        OPSZ_16 = 2'b01,
        OPSZ_32 = 2'b10,
        OPSZ_64 = 2'b11
    } opsz_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hi;
        logic             bad;
    } spec_t;
endpackage

// File: rtl/prf_spec_map.sv
// Maps an operand specifier (code, extension, prefix flag, size) to a
// register index, a high-byte select and a bad-specifier flag.
// Assumes a 3-bit code and the prefix flag already extracted upstream.
module prf_spec_map
    import prf_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    input  logic              ext,
    input  logic              pfx,
    input  opsz_e             size,
    output spec_t             spec
);
    localparam int LOW_W = CODE_W - 1;

    // Purpose: pick the index and lane per prefix and size rules.
    always_comb begin
        spec.bad = ext & ~pfx;
        spec.hi  = 1'b0;
        if (pfx) begin
            spec.idx = {ext, code};
        end else if (size == OPSZ_8 && code[CODE_W-1]) begin
            spec.idx = {{(IDX_W-LOW_W){1'b0}}, code[LOW_W-1:0]};
            spec.hi  = 1'b1;
        end else begin
            spec.idx = {1'b0, code};
        end
    end
endmodule

// File: rtl/prf_read_slice.sv
// Extracts the addressed slice of one register and zero-extends it.
// Assumes a bad specifier must read as zero.
module prf_read_slice
    import prf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] word,
    input  opsz_e           size,
    input  logic            hi,
    input  logic            bad,
    output logic [XLEN-1:0] data
);
    // Purpose: select and zero-extend the slice for the operand size.
    always_comb begin
        data = '0;
        if (!bad) begin
            unique case (size)
                OPSZ_8:  data[7:0]  = hi ? word[15:8] : word[7:0];
                OPSZ_16: data[15:0] = word[15:0];
                OPSZ_32: data[31:0] = word[31:0];
                default: data       = word;
            endcase
        end
    end
endmodule

// File: rtl/prf_lane_merge.sv
// Builds the next register value for a write of a given size.
// Byte and word writes keep the other bits; 32-bit writes clear the top half.
module prf_lane_merge
    import prf_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] wdata,
    input  opsz_e           size,
    input  logic            hi,
    output logic [XLEN-1:0] new_word
);
    // Purpose: merge the write slice into the old register contents.
    always_comb begin
        new_word = old_word;
        unique case (size)
            OPSZ_8: begin
                if (hi) new_word[15:8] = wdata[7:0];
                else    new_word[7:0]  = wdata[7:0];
            end
            OPSZ_16: new_word[15:0] = wdata[15:0];
            OPSZ_32: new_word = {{(XLEN-32){1'b0}}, wdata[31:0]};
            default: new_word = wdata;
        endcase
    end
endmodule

// File: rtl/partreg_file.sv
// Sixteen-entry register file with two combinational read ports and one
// clocked write port, each addressed by a prefix-aware operand specifier.
// Assumes a synchronous active-low reset and no write-to-read bypass.
module partreg_file
    import prf_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NREG   = 16,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ra_code,
    input  logic              ra_ext,
    input  logic              ra_pfx,
    input  logic [1:0]        ra_size,
    output logic [XLEN-1:0]   ra_data,
    output logic              ra_bad,
    input  logic [CODE_W-1:0] rb_code,
    input  logic              rb_ext,
    input  logic              rb_pfx,
    input  logic [1:0]        rb_size,
    output logic [XLEN-1:0]   rb_data,
    output logic              rb_bad,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_ext,
    input  logic              wr_pfx,
    input  logic [1:0]        wr_size,
    input  logic [XLEN-1:0]   wr_data,
    output logic              wr_bad
);
    logic [XLEN-1:0] regs_q [NREG];
    spec_t           spec_a, spec_b, spec_w;
    logic [XLEN-1:0] merged;
    logic [NREG-1:0] wr_hit;

    prf_spec_map #(.CODE_W(CODE_W)) map_a_i (
        .code(ra_code), .ext(ra_ext), .pfx(ra_pfx), .size(opsz_e'(ra_size)), .spec(spec_a));
    prf_spec_map #(.CODE_W(CODE_W)) map_b_i (
        .code(rb_code), .ext(rb_ext), .pfx(rb_pfx), .size(opsz_e'(rb_size)), .spec(spec_b));
    prf_spec_map #(.CODE_W(CODE_W)) map_w_i (
        .code(wr_code), .ext(wr_ext), .pfx(wr_pfx), .size(opsz_e'(wr_size)), .spec(spec_w));

    prf_read_slice #(.XLEN(XLEN)) rd_a_i (
        .word(regs_q[spec_a.idx]), .size(opsz_e'(ra_size)), .hi(spec_a.hi),
        .bad(spec_a.bad), .data(ra_data));
    prf_read_slice #(.XLEN(XLEN)) rd_b_i (
        .word(regs_q[spec_b.idx]), .size(opsz_e'(rb_size)), .hi(spec_b.hi),
        .bad(spec_b.bad), .data(rb_data));

    prf_lane_merge #(.XLEN(XLEN)) merge_i (
        .old_word(regs_q[spec_w.idx]), .wdata(wr_data), .size(opsz_e'(wr_size)),
        .hi(spec_w.hi), .new_word(merged));

    assign ra_bad = spec_a.bad;
    assign rb_bad = spec_b.bad;
    assign wr_bad = spec_w.bad;

    // Purpose: one-hot write select, gated off for bad specifiers.
    always_comb begin
        wr_hit = '0;
        if (wr_en && !spec_w.bad) wr_hit[spec_w.idx] = 1'b1;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Purpose: clear on reset, else take the merged value when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)         regs_q[g] <= '0;
            else if (wr_hit[g]) regs_q[g] <= merged;
        end
    end

    // R11: reads are zero after a reset edge.
    assert_reset_clears_R11: assert property (@(posedge clk)
        !rst_n |=> (ra_data == '0 && rb_data == '0));
    // R5: a bad read returns zero.
    assert_bad_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_ext && !ra_pfx) |-> (ra_bad && ra_data == '0));
    // R13: prefixed specifiers never select the high byte.
    assert_pfx_no_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_pfx || ra_pfx) |-> !((rb_pfx && spec_b.hi) || (ra_pfx && spec_a.hi)));
    // R6: a bad write leaves the aimed register unchanged.
    assert_bad_write_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bad) |=> regs_q[$past(spec_w.idx)] == $past(regs_q[spec_w.idx]));
    // R8: a 32-bit write leaves the upper half zero.
    assert_w32_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bad && wr_size == 2'b10) |=> regs_q[$past(spec_w.idx)][XLEN-1:32] == '0);
    // R7: a low-byte write keeps bits above the byte.
    assert_w8_keeps_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bad && wr_size == 2'b00 && !spec_w.hi)
        |=> regs_q[$past(spec_w.idx)][XLEN-1:8] == $past(regs_q[spec_w.idx][XLEN-1:8]));
endmodule

// File: tb/partreg_file_tb_top.sv
// Directed bench: each task drives one scenario and checks its own results
// against a reference model kept in the bench.
module partreg_file_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ra_code = '0, rb_code = '0, wr_code = '0;
    logic        ra_ext = 1'b0, rb_ext = 1'b0, wr_ext = 1'b0;
    logic        ra_pfx = 1'b0, rb_pfx = 1'b0, wr_pfx = 1'b0;
    logic [1:0]  ra_size = 2'b11, rb_size = 2'b11, wr_size = 2'b11;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] ra_data, rb_data;
    logic        ra_bad, rb_bad, wr_bad;

    logic [63:0] model [16];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    partreg_file dut_i (
        .clk(clk), .rst_n(rst_n),
        .ra_code(ra_code), .ra_ext(ra_ext), .ra_pfx(ra_pfx), .ra_size(ra_size),
        .ra_data(ra_data), .ra_bad(ra_bad),
        .rb_code(rb_code), .rb_ext(rb_ext), .rb_pfx(rb_pfx), .rb_size(rb_size),
        .rb_data(rb_data), .rb_bad(rb_bad),
        .wr_en(wr_en), .wr_code(wr_code), .wr_ext(wr_ext), .wr_pfx(wr_pfx),
        .wr_size(wr_size), .wr_data(wr_data), .wr_bad(wr_bad));

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference decode: returns {bad, hi, idx}
    function automatic logic [5:0] ref_map(logic [2:0] c, logic e, logic p, logic [1:0] s);
        if (e && !p)            return {1'b1, 1'b0, 4'd0};
        if (p)                  return {1'b0, 1'b0, e, c};
        if (s == 2'b00 && c[2]) return {1'b0, 1'b1, 2'b00, c[1:0]};
        return {1'b0, 1'b0, 1'b0, c};
    endfunction

    function automatic logic [63:0] ref_read(logic [2:0] c, logic e, logic p, logic [1:0] s);
        logic [5:0]  m = ref_map(c, e, p, s);
        logic [63:0] w = model[m[3:0]];
        if (m[5]) return '0;
        case (s)
            2'b00:   return m[4] ? {56'b0, w[15:8]} : {56'b0, w[7:0]};
            2'b01:   return {48'b0, w[15:0]};
            2'b10:   return {32'b0, w[31:0]};
            default: return w;
        endcase
    endfunction

    task automatic model_write(logic [2:0] c, logic e, logic p, logic [1:0] s, logic [63:0] d);
        logic [5:0] m = ref_map(c, e, p, s);
        if (m[5]) return;
        case (s)
            2'b00: if (m[4]) model[m[3:0]][15:8] = d[7:0];
                   else      model[m[3:0]][7:0]  = d[7:0];
            2'b01: model[m[3:0]][15:0] = d[15:0];
            2'b10: model[m[3:0]] = {32'b0, d[31:0]};
            default: model[m[3:0]] = d;
        endcase
    endtask

    task automatic do_write(logic [2:0] c, logic e, logic p, logic [1:0] s, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_code = c; wr_ext = e; wr_pfx = p; wr_size = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(c, e, p, s, d);
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
    endtask

    // R11: all registers read zero after reset
    task automatic t_reset_zero();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rb_code = i[2:0]; rb_ext = i[3]; rb_pfx = 1'b1; rb_size = 2'b11;
            #1 check("R11", rb_data, 64'h0);
        end
    endtask

    // R9 R4: full-width writes to all sixteen registers, distinct bytes
    task automatic t_fill();
        for (int i = 0; i < 16; i++) begin
            logic [63:0] v;
            for (int b = 0; b < 8; b++) v[b*8 +: 8] = {i[3:0], b[3:0]};
            do_write(i[2:0], i[3], 1'b1, 2'b11, v);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ra_code = i[2:0]; ra_ext = i[3]; ra_pfx = 1'b1; ra_size = 2'b11;
            #1 check("R9", ra_data, model[i]);
        end
    endtask

    // R1 R2 R3 R4 R5 R10 R13: every read specifier on both ports
    task automatic t_read_sweep();
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 2; p++)
                for (int e = 0; e < 2; e++)
                    for (int c = 0; c < 8; c++) begin
                        string tag;
                        logic [63:0] exp;
                        if (e == 1 && p == 0)      tag = "R5";
                        else if (s == 0 && p == 0) tag = "R2/R10";
                        else if (s == 0)           tag = "R3/R13";
                        else if (p == 1)           tag = "R4/R10";
                        else                       tag = "R1/R10";
                        @(negedge clk);
                        ra_code = c[2:0]; ra_ext = e[0]; ra_pfx = p[0]; ra_size = s[1:0];
                        rb_code = c[2:0]; rb_ext = e[0]; rb_pfx = p[0]; rb_size = s[1:0];
                        exp = ref_read(c[2:0], e[0], p[0], s[1:0]);
                        #1;
                        check(tag, ra_data, exp);
                        check(tag, rb_data, exp);
                        check("R5", {63'b0, ra_bad}, {63'b0, (e == 1 && p == 0)});
                    end
    endtask

    // R6 R7 R8: every write specifier, whole register read back
    task automatic t_write_sweep();
        int k = 0;
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 2; p++)
                for (int e = 0; e < 2; e++)
                    for (int c = 0; c < 8; c++) begin
                        logic [5:0]  m = ref_map(c[2:0], e[0], p[0], s[1:0]);
                        logic [63:0] d = 64'hA5C3_1E0F_7B29_64D8 ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15);
                        string tag;
                        k++;
                        if (m[5])        tag = "R6";
                        else if (s == 2) tag = "R8";
                        else if (s == 3) tag = "R9";
                        else             tag = "R7";
                        do_write(c[2:0], e[0], p[0], s[1:0], d);
                        for (int r = 0; r < 16; r += 5) begin
                            ra_code = r[2:0]; ra_ext = r[3]; ra_pfx = 1'b1; ra_size = 2'b11;
                            #1 check(tag, ra_data, model[r]);
                        end
                        rb_code = m[2:0]; rb_ext = m[3]; rb_pfx = 1'b1; rb_size = 2'b11;
                        #1 check(tag, rb_data, model[m[3:0]]);
                    end
    endtask

    // R12: read during a write returns the value before the edge
    task automatic t_same_cycle();
        logic [63:0] old_v = model[6];
        @(negedge clk);
        wr_en = 1'b1; wr_code = 3'd6; wr_ext = 1'b0; wr_pfx = 1'b0; wr_size = 2'b11;
        wr_data = 64'hDEAD_BEEF_0123_4567;
        ra_code = 3'd6; ra_ext = 1'b0; ra_pfx = 1'b0; ra_size = 2'b11;
        #1 check("R12", ra_data, old_v);
        @(negedge clk);
        wr_en = 1'b0;
        model[6] = 64'hDEAD_BEEF_0123_4567;
        #1 check("R12", ra_data, model[6]);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        apply_reset();
        t_reset_zero();
        t_fill();
        t_read_sweep();
        t_write_sweep();
        t_same_cycle();
        t_fill();
        apply_reset();
        t_reset_zero();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule